// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block watches a set of level-sensitive interrupt lines and turns each new assertion into one 64-bit store on a bus-master port. The store goes to a programmable notification address. Its data word is built from a fixed trigger flag, the upper half of a vector-offset register and the number of the source that fired. A downstream interrupt controller decodes these stores. The controller itself, and any event-state storage behind the block, are outside this block.

Software sets the block up through a simple register port with 64-bit write and read access. There are four configuration registers and one read-only level register. Bit fields use MSB-first numbering: field bit n is value bit 63-n. Sources that fire while a store is still in flight are held in a pending vector. They are served one at a time, lowest source number first. A control bit can freeze the level register, and a second control bit clears all source state.

Top module: `nfy_trigger_notifier`

## Requirements
- R1: After reset, the control, window-base, notify-address, offset and level registers all read zero, `nfy_req_valid` is low, `nfy_err` is low and `lvl_ign` is low.
- R2: Register offsets are control 0x58, window base 0x60, notify address 0x68 and vector offset 0x70. Each of these is written whole and reads back the value written. A read of any offset other than 0x58, 0x60, 0x68, 0x70 or 0x78 returns all ones. A write to such an offset changes nothing.
- R3: Offset 0x78 is the level register and is read-only. Source n appears at value bit 63-n, one clock after the input changes.
- R4: A 0-to-1 change of a source, compared with the level register, queues that source. The store address is the notify-address value with bit 0 cleared. `nfy_req_valid` stays high, with address and data unchanged, until `nfy_req_ready` is sampled high.
- R5: The store data is 0x8000_0000_0000_0000 ORed with bits 63:32 of the offset register, shifted down to bits 31:0, and ORed with the source number.
- R6: When value bit 0 of the notify-address register is clear, a queued source is taken from the queue and discarded, and no store is issued.
- R7: Queued sources are served lowest number first. Only one store is outstanding at a time: after a request is accepted, no new request starts until `nfy_resp_valid` has been seen.
- R8: A response with `nfy_resp_err` high gives a one-cycle `nfy_err` pulse in the cycle after the response. The failed store is not issued again.
- R9: While value bit 63 of the control register is set, input changes do not update the level register and queue nothing. In that mode, `lvl_ign` is high in the cycle after any clock edge where an input differs from the level register.
- R10: A control write with value bit 62 set clears the level register and the whole pending queue at that clock edge. A store already outstanding still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Level-sensitive interrupt sources |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for `cfg_addr` (combinational) |
| nfy_req_valid | output | 1 | Notification store request |
| nfy_req_ready | input | 1 | Store accepted by the bus |
| nfy_req_addr | output | 64 | Store address |
| nfy_req_data | output | 64 | Store data |
| nfy_resp_valid | input | 1 | Store response |
| nfy_resp_err | input | 1 | Store response carries an error |
| nfy_err | output | 1 | One-cycle pulse on an error response |
| lvl_ign | output | 1 | Input change ignored while the level register is frozen |

## Verification
The hardest situation to reach is a control-register clear that lands while one store waits for `nfy_req_ready` and another source sits in the pending queue. To get there, the bench slave holds `ready` off for several cycles, two sources are raised together, and the clear is written in the same cycle that the inputs drop. A design that only cleared the level register would still send the second source, and the store-order record would show it. The ordering check works the same way: three sources rise in one cycle behind a slow slave, and the recorded order of source numbers is compared with lowest-first order.

// File: rtl/nfy_pkg.sv
package nfy_pkg;

    localparam int unsigned REG_W  = 64;
    localparam int unsigned CFG_AW = 8;

    // register byte offsets
    localparam logic [CFG_AW-1:0] OFS_CTRL = 8'h58;
    localparam logic [CFG_AW-1:0] OFS_WIN  = 8'h60;
    localparam logic [CFG_AW-1:0] OFS_NFY  = 8'h68;
    localparam logic [CFG_AW-1:0] OFS_VEC  = 8'h70;
    localparam logic [CFG_AW-1:0] OFS_LVL  = 8'h78;

    // MSB-first field numbering: field bit n lives at value bit REG_W-1-n
    function automatic int unsigned msb_pos(input int unsigned n);
        return REG_W - 1 - n;
    endfunction

    localparam int unsigned FREEZE_BIT = msb_pos(0);
    localparam int unsigned CLEAR_BIT  = msb_pos(1);
    localparam int unsigned VALID_BIT  = msb_pos(63);

    localparam logic [REG_W-1:0] TRIG_FLAG_DEF = 64'h8000_0000_0000_0000;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_REQ  = 2'd1,
        MS_RESP = 2'd2
    } mst_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] win;
        logic [REG_W-1:0] nfy;
        logic [REG_W-1:0] vec;
    } cfg_t;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [REG_W-1:0] data;
    } store_t;

endpackage

// File: rtl/nfy_cfg_regs.sv
module nfy_cfg_regs
    import nfy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  lvl_word,
    output logic [REG_W-1:0]  rdata,
    output logic              freeze_o,
    output logic              clear_o,
    output logic [REG_W-1:0]  nfy_o,
    output logic [31:0]       vec_hi_o
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_CTRL: cfg_q.ctrl <= wdata;
                OFS_WIN:  cfg_q.win  <= wdata;
                OFS_NFY:  cfg_q.nfy  <= wdata;
                OFS_VEC:  cfg_q.vec  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rdata = cfg_q.ctrl;
            OFS_WIN:  rdata = cfg_q.win;
            OFS_NFY:  rdata = cfg_q.nfy;
            OFS_VEC:  rdata = cfg_q.vec;
            OFS_LVL:  rdata = lvl_word;
            default:  rdata = '1;
        endcase
    end

    assign clear_o  = wr_en && (addr == OFS_CTRL) && wdata[CLEAR_BIT];
    assign freeze_o = cfg_q.ctrl[FREEZE_BIT];
    assign nfy_o    = cfg_q.nfy;
    assign vec_hi_o = cfg_q.vec[REG_W-1:32];

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q)) else $error("config changed without write"); // R2

endmodule

// File: rtl/nfy_src_track.sv
module nfy_src_track
    import nfy_pkg::*;
#(
    parameter int unsigned NUM_SRC = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic               freeze_i,
    input  logic               clear_i,
    input  logic [NUM_SRC-1:0] take_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [REG_W-1:0]   lvl_word_o,
    output logic               ign_o
);

    logic [NUM_SRC-1:0] lvl_q;
    logic [NUM_SRC-1:0] pend_q;
    logic               ign_q;
    logic [NUM_SRC-1:0] rise;

    assign rise = irq_i & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            lvl_q  <= '0;
            pend_q <= '0;
            ign_q  <= 1'b0;
        end else begin
            ign_q <= freeze_i && (irq_i != lvl_q);
            if (freeze_i) begin
                pend_q <= pend_q & ~take_i;
            end else begin
                pend_q <= (pend_q & ~take_i) | rise;
                lvl_q  <= irq_i;
            end
        end
    end

    genvar n;
    generate
        for (n = 0; n < REG_W; n++) begin : g_lvl_map
            if (n < NUM_SRC) begin : g_src
                assign lvl_word_o[msb_pos(n)] = lvl_q[n];
            end else begin : g_pad
                assign lvl_word_o[msb_pos(n)] = 1'b0;
            end
        end
    endgenerate

    assign pend_o = pend_q;
    assign ign_o  = ign_q;

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        freeze_i && !clear_i |=> $stable(lvl_q)) else $error("level moved while frozen"); // R9

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (pend_q == '0) && (lvl_q == '0)) else $error("state survived clear"); // R10

endmodule

// File: rtl/nfy_pick.sv
module nfy_pick #(
    parameter int unsigned NUM_SRC = 20,
    parameter int unsigned SRC_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               any_o,
    output logic [SRC_W-1:0]   idx_o,
    output logic [NUM_SRC-1:0] onehot_o
);

    always_comb begin
        idx_o    = '0;
        onehot_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = SRC_W'(i);
            end
        end
        any_o = |pend_i;
        if (any_o) begin
            onehot_o[idx_o] = 1'b1;
        end
    end

endmodule

// File: rtl/nfy_bus_master.sv
module nfy_bus_master
    import nfy_pkg::*;
#(
    parameter int unsigned      SRC_W     = 5,
    parameter logic [REG_W-1:0] TRIG_FLAG = TRIG_FLAG_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_i,
    input  logic [SRC_W-1:0]  idx_i,
    input  logic              clear_i,
    input  logic [REG_W-1:0]  nfy_i,
    input  logic [31:0]       vec_hi_i,
    output logic              take_o,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [REG_W-1:0]  req_addr,
    output logic [REG_W-1:0]  req_data,
    input  logic              resp_valid,
    input  logic              resp_err,
    output logic              err_o
);

    mst_e   st_q;
    store_t st_buf;
    logic   err_q;

    assign take_o = (st_q == MS_IDLE) && any_i && !clear_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= MS_IDLE;
            st_buf <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (st_q)
                MS_IDLE: begin
                    if (take_o && nfy_i[VALID_BIT]) begin
                        st_q        <= MS_REQ;
                        st_buf.addr <= {nfy_i[REG_W-1:1], 1'b0};
                        st_buf.data <= TRIG_FLAG | {32'h0, vec_hi_i} | REG_W'(idx_i);
                    end
                end
                MS_REQ: begin
                    if (req_ready) st_q <= MS_RESP;
                end
                MS_RESP: begin
                    if (resp_valid) begin
                        err_q <= resp_err;
                        st_q  <= MS_IDLE;
                    end
                end
                default: st_q <= MS_IDLE;
            endcase
        end
    end

    assign req_valid = (st_q == MS_REQ);
    assign req_addr  = st_buf.addr;
    assign req_data  = st_buf.data;
    assign err_o     = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data))
        else $error("request dropped or changed"); // R4

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o) else $error("error longer than one cycle"); // R8

    AST_ERR_FROM_RESP: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(resp_valid && resp_err)) else $error("error without response"); // R8

endmodule

// File: rtl/nfy_trigger_notifier.sv
module nfy_trigger_notifier
    import nfy_pkg::*;
#(
    parameter int unsigned      NUM_SRC   = 20,
    parameter logic [REG_W-1:0] TRIG_FLAG = TRIG_FLAG_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [63:0]        cfg_wdata,
    output logic [63:0]        cfg_rdata,
    output logic               nfy_req_valid,
    input  logic               nfy_req_ready,
    output logic [63:0]        nfy_req_addr,
    output logic [63:0]        nfy_req_data,
    input  logic               nfy_resp_valid,
    input  logic               nfy_resp_err,
    output logic               nfy_err,
    output logic               lvl_ign
);

    localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic               freeze;
    logic               clear;
    logic [REG_W-1:0]   nfy_word;
    logic [31:0]        vec_hi;
    logic [REG_W-1:0]   lvl_word;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] take_vec;
    logic               any_pend;
    logic [SRC_W-1:0]   pick_idx;
    logic               take;

    nfy_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .lvl_word (lvl_word),
        .rdata    (cfg_rdata),
        .freeze_o (freeze),
        .clear_o  (clear),
        .nfy_o    (nfy_word),
        .vec_hi_o (vec_hi)
    );

    nfy_src_track #(.NUM_SRC(NUM_SRC)) u_track (
        .clk        (clk),
        .rst        (rst),
        .irq_i      (irq_in),
        .freeze_i   (freeze),
        .clear_i    (clear),
        .take_i     (take_vec),
        .pend_o     (pend),
        .lvl_word_o (lvl_word),
        .ign_o      (lvl_ign)
    );

    nfy_pick #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pick (
        .pend_i   (pend),
        .any_o    (any_pend),
        .idx_o    (pick_idx),
        .onehot_o (grant)
    );

    assign take_vec = grant & {NUM_SRC{take}};

    nfy_bus_master #(.SRC_W(SRC_W), .TRIG_FLAG(TRIG_FLAG)) u_mst (
        .clk        (clk),
        .rst        (rst),
        .any_i      (any_pend),
        .idx_i      (pick_idx),
        .clear_i    (clear),
        .nfy_i      (nfy_word),
        .vec_hi_i   (vec_hi),
        .take_o     (take),
        .req_valid  (nfy_req_valid),
        .req_ready  (nfy_req_ready),
        .req_addr   (nfy_req_addr),
        .req_data   (nfy_req_data),
        .resp_valid (nfy_resp_valid),
        .resp_err   (nfy_resp_err),
        .err_o      (nfy_err)
    );

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("multiple grants"); // R7

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> (((grant - 1'b1) & pend) == '0)) else $error("grant not lowest"); // R7

    AST_SEND_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(nfy_req_valid) |-> $past(nfy_word[VALID_BIT])) else $error("store without valid"); // R6

endmodule

// File: tb/nfy_trigger_notifier_tb.sv
`timescale 1ns/1ps
module nfy_trigger_notifier_tb;

    localparam int NS = 20;
    localparam logic [63:0] FLAG = 64'h8000_0000_0000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_in = '0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = 8'h78;
    logic [63:0]   cfg_wdata = '0;
    logic [63:0]   cfg_rdata;
    logic          nfy_req_valid;
    logic          nfy_req_ready = 1'b0;
    logic [63:0]   nfy_req_addr;
    logic [63:0]   nfy_req_data;
    logic          nfy_resp_valid = 1'b0;
    logic          nfy_resp_err = 1'b0;
    logic          nfy_err;
    logic          lvl_ign;

    always #2.5 clk = ~clk;

    nfy_trigger_notifier #(.NUM_SRC(NS)) u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .nfy_req_valid(nfy_req_valid), .nfy_req_ready(nfy_req_ready),
        .nfy_req_addr(nfy_req_addr), .nfy_req_data(nfy_req_data),
        .nfy_resp_valid(nfy_resp_valid), .nfy_resp_err(nfy_resp_err),
        .nfy_err(nfy_err), .lvl_ign(lvl_ign)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit [63:0] m_ctrl, m_win, m_nfy, m_vec, m_addr, m_data;
    bit [NS-1:0] m_lvl, m_pend;
    int m_state;  // 0 idle, 1 requesting, 2 awaiting response
    bit m_err, m_ign;

    function automatic bit [63:0] m_level_word();
        bit [63:0] w = '0;
        for (int n = 0; n < NS; n++) w[63-n] = m_lvl[n];
        return w;
    endfunction

    function automatic bit [63:0] m_read(input bit [7:0] a);
        case (a)
            8'h58: return m_ctrl;
            8'h60: return m_win;
            8'h68: return m_nfy;
            8'h70: return m_vec;
            8'h78: return m_level_word();
            default: return '1;
        endcase
    endfunction

    task automatic model_step();
        bit clr = cfg_we && (cfg_addr == 8'h58) && cfg_wdata[62];
        bit nerr = (m_state == 2) && nfy_resp_valid && nfy_resp_err;
        int gi = -1;
        case (m_state)
            0: if (m_pend != 0 && !clr) begin
                   for (int i = NS - 1; i >= 0; i--) if (m_pend[i]) gi = i;
                   m_pend[gi] = 1'b0;
                   if (m_nfy[0]) begin
                       m_state = 1;
                       m_addr = {m_nfy[63:1], 1'b0};
                       m_data = FLAG | {32'h0, m_vec[63:32]} | 64'(gi);
                   end
               end
            1: if (nfy_req_ready) m_state = 2;
            default: if (nfy_resp_valid) m_state = 0;
        endcase
        m_ign = !clr && m_ctrl[63] && (irq_in != m_lvl);
        if (clr) begin
            m_lvl = '0; m_pend = '0;
        end else if (!m_ctrl[63]) begin
            m_pend = m_pend | (irq_in & ~m_lvl);
            m_lvl = irq_in;
        end
        m_err = nerr;
        if (cfg_we) begin
            case (cfg_addr)
                8'h58: m_ctrl = cfg_wdata;
                8'h60: m_win = cfg_wdata;
                8'h68: m_nfy = cfg_wdata;
                8'h70: m_vec = cfg_wdata;
                default: ;
            endcase
        end
    endtask

    int err_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            m_ctrl = 0; m_win = 0; m_nfy = 0; m_vec = 0; m_addr = 0; m_data = 0;
            m_lvl = 0; m_pend = 0; m_state = 0; m_err = 0; m_ign = 0;
        end else begin
            model_step();
        end
        check(nfy_req_valid == (m_state == 1), "R4 req_valid", 64'(nfy_req_valid), 64'(m_state == 1));
        if (m_state == 1) begin
            check(nfy_req_addr == m_addr, "R4 req_addr", nfy_req_addr, m_addr);
            check(nfy_req_data == m_data, "R5 req_data", nfy_req_data, m_data);
        end
        check(nfy_err == m_err, "R8 nfy_err", 64'(nfy_err), 64'(m_err));
        check(lvl_ign == m_ign, "R9 lvl_ign", 64'(lvl_ign), 64'(m_ign));
        check(cfg_rdata == m_read(cfg_addr), (cfg_addr == 8'h78) ? "R3 level read" : "R2 reg read",
              cfg_rdata, m_read(cfg_addr));
        if (nfy_err) err_seen++;
        if (cyc > 20000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog got=%0d exp=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- bus slave ----------------
    int rdy_dly = 0, rsp_dly = 0, s_st = 0, s_cnt = 0;
    bit err_mode = 0;
    logic [63:0] got_q[$];
    logic [63:0] got_a[$];

    always @(negedge clk) begin
        #1;
        nfy_req_ready = 1'b0; nfy_resp_valid = 1'b0; nfy_resp_err = 1'b0;
        if (rst) begin
            s_st = 0; s_cnt = 0;
        end else if (s_st == 0) begin
            if (nfy_req_valid) begin
                if (s_cnt >= rdy_dly) begin
                    nfy_req_ready = 1'b1;
                    got_q.push_back(nfy_req_data);
                    got_a.push_back(nfy_req_addr);
                    s_st = 1; s_cnt = 0;
                end else s_cnt++;
            end
        end else begin
            if (s_cnt >= rsp_dly) begin
                nfy_resp_valid = 1'b1; nfy_resp_err = err_mode;
                s_st = 0; s_cnt = 0;
            end else s_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_addr = 8'h78;
    endtask

    task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
        cfg_addr = a;
        tick();
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
        cfg_addr = 8'h78;
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick();
        // R1 reset state
        rd(8'h58, 64'h0, "R1 ctrl reset");
        rd(8'h60, 64'h0, "R1 win reset");
        rd(8'h68, 64'h0, "R1 nfy reset");
        rd(8'h70, 64'h0, "R1 vec reset");
        rd(8'h78, 64'h0, "R1 level reset");
        check(!nfy_req_valid && !nfy_err && !lvl_ign, "R1 outputs idle", 64'(nfy_req_valid), 0);

        // R2 readback, unmapped and read-only offsets
        wr(8'h60, 64'hDEAD_BEEF_0000_0001);
        rd(8'h60, 64'hDEAD_BEEF_0000_0001, "R2 win readback");
        rd(8'h40, 64'hFFFF_FFFF_FFFF_FFFF, "R2 unmapped read");
        wr(8'h50, 64'h1234);
        rd(8'h50, 64'hFFFF_FFFF_FFFF_FFFF, "R2 unmapped write ignored");
        wr(8'h78, 64'hFFFF_0000_0000_0000);
        rd(8'h78, 64'h0, "R3 level read-only");

        // R4 R5 single trigger
        wr(8'h68, 64'h0000_00AB_CDEF_1001);
        wr(8'h70, 64'h0000_0200_1234_5678);
        rd(8'h68, 64'h0000_00AB_CDEF_1001, "R2 nfy readback");
        rdy_dly = 1; rsp_dly = 2;
        irq_in[3] = 1'b1;
        tick(12);
        check(got_q.size() == 1, "R4 one store", 64'(got_q.size()), 1);
        if (got_q.size() == 1) begin
            check(got_a[0] == 64'h0000_00AB_CDEF_1000, "R4 store addr", got_a[0], 64'h0000_00AB_CDEF_1000);
            check(got_q[0] == (FLAG | 64'h200 | 64'd3), "R5 store data", got_q[0], FLAG | 64'h200 | 64'd3);
        end
        rd(8'h78, 64'h1 << 60, "R3 level bit for source 3");

        // R7 ordering
        got_q.delete(); got_a.delete();
        rdy_dly = 3; rsp_dly = 3;
        irq_in[19] = 1'b1; irq_in[5] = 1'b1; irq_in[1] = 1'b1;
        tick(50);
        check(got_q.size() == 3, "R7 three stores", 64'(got_q.size()), 3);
        if (got_q.size() == 3) begin
            check(got_q[0][4:0] == 5'd1,  "R7 first lowest", 64'(got_q[0][4:0]), 1);
            check(got_q[1][4:0] == 5'd5,  "R7 second", 64'(got_q[1][4:0]), 5);
            check(got_q[2][4:0] == 5'd19, "R7 third", 64'(got_q[2][4:0]), 19);
        end

        // R8 error response, no retry
        got_q.delete(); got_a.delete();
        irq_in = '0;
        tick(3);
        err_mode = 1; err_seen = 0;
        irq_in[7] = 1'b1;
        tick(25);
        check(err_seen == 1, "R8 one error pulse", 64'(err_seen), 1);
        check(got_q.size() == 1, "R8 no retry", 64'(got_q.size()), 1);
        err_mode = 0;

        // R6 valid bit clear drops triggers
        got_q.delete(); got_a.delete();
        wr(8'h68, 64'h0000_00AB_CDEF_1000);
        irq_in[9] = 1'b1;
        tick(10);
        wr(8'h68, 64'h0000_00AB_CDEF_1001);
        tick(10);
        check(got_q.size() == 0, "R6 no store without valid", 64'(got_q.size()), 0);

        // R9 frozen level register
        irq_in = '0;
        tick(3);
        wr(8'h58, 64'h8000_0000_0000_0000);
        irq_in[2] = 1'b1;
        tick(2);
        check(lvl_ign == 1'b1, "R9 ignore flag", 64'(lvl_ign), 1);
        rd(8'h78, 64'h0, "R9 level frozen");
        irq_in[2] = 1'b0;
        tick(2);
        wr(8'h58, 64'h0);
        tick(10);
        check(got_q.size() == 0, "R9 no store while frozen", 64'(got_q.size()), 0);

        // R10 clear with one store outstanding and one pending
        rdy_dly = 8; rsp_dly = 1;
        irq_in[11] = 1'b1; irq_in[12] = 1'b1;
        tick(3);
        irq_in = '0;
        wr(8'h58, 64'h4000_0000_0000_0000);
        tick(30);
        check(got_q.size() == 1, "R10 pending cleared", 64'(got_q.size()), 1);
        if (got_q.size() >= 1)
            check(got_q[0][4:0] == 5'd11, "R10 outstanding completes", 64'(got_q[0][4:0]), 11);
        rd(8'h78, 64'h0, "R10 level cleared");
        rd(8'h58, 64'h4000_0000_0000_0000, "R2 ctrl readback");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule